// File: doc/BRIEF.md
# Load/Store Processor Instruction Decoder

This block turns a 32-bit instruction word of a single-cycle 64-bit load/store processor into the control set that steers the rest of the datapath. It recognises six encodings by their top eleven bits:

- add and subtract with a register second operand
- add with an unsigned 12-bit immediate
- AND with an immediate
- unscaled load
- unscaled store

For each encoding it produces the three register-file selects, a two-bit ALU operation, a three-way choice for the ALU's second operand, and the extended immediate that goes with that choice. It also drives the register write enable, the memory read and write strobes, and the writeback source.

The decode is combinational. Its result is held in one output register, so an instruction word presented before a rising clock edge is reflected on the outputs after that edge. Any word outside the subset yields a harmless control set: nothing is written to the register file and memory is not touched. The register file, ALU, memories and branch logic are separate blocks that consume these outputs.

Top module: `idec_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is zero after that edge, whatever `insn` holds.
- R2: Outputs change only at a rising edge, and after an edge they reflect the `insn` value sampled at that edge; between edges they hold.
- R3: `sel_a` equals `insn[9:5]` and `sel_w` equals `insn[4:0]` for every word. `sel_b` equals `insn[4:0]` for a store and `insn[20:16]` for every other word.
- R4: A register-format arithmetic word matches `insn[31:21]` = 10001011xx0 (add) or 11001011xx0 (subtract). It gives `reg_we`=1, `opnd_sel`=0 (register), `mem_rd`=0, `mem_wr`=0 and `wb_from_mem`=0. It also gives `alu_op` = `insn[30:29]`, which is 00 for add and 10 for subtract.
- R5: An add-immediate word (`insn[31:21]` = 10010001xxx) gives `reg_we`=1, `opnd_sel`=1, `alu_op`=00, no memory access and `wb_from_mem`=0.
- R6: An AND-immediate word (`insn[31:21]` = 100100100xx) gives `reg_we`=1, `opnd_sel`=1, `alu_op`=01 (AND), no memory access and `wb_from_mem`=0.
- R7: A load word (`insn[31:21]` = 1x111000010) gives `reg_we`=1, `mem_rd`=1, `mem_wr`=0, `wb_from_mem`=1 and `opnd_sel`=2. It forces `alu_op`=00 whatever `insn[30]` holds.
- R8: A store word (`insn[31:21]` = 1x111000000) gives `reg_we`=0, `mem_rd`=0, `mem_wr`=1, `wb_from_mem`=0, `opnd_sel`=2 and `alu_op`=00.
- R9: Any other word gives `reg_we`=0, `mem_rd`=0, `mem_wr`=0, `wb_from_mem`=0, `opnd_sel`=0 and `alu_op`=00.
- R10: `mem_rd` and `mem_wr` are never 1 together, and `opnd_sel` never takes the value 3.
- R11: `opnd_imm` depends on `opnd_sel`. When it is 1, `opnd_imm` is `insn[21:10]` zero-extended to 64 bits. When it is 2, `opnd_imm` is `insn[20:12]` sign-extended to 64 bits. When it is 0, `opnd_imm` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| insn | input | 32 | Instruction word to decode |
| sel_a | output | 5 | First source register select |
| sel_b | output | 5 | Second source register select |
| sel_w | output | 5 | Destination register select |
| alu_op | output | 2 | ALU operation: 00 add, 01 AND, 10 subtract |
| opnd_sel | output | 2 | ALU second operand: 0 register, 1 zero-extended imm12, 2 sign-extended imm9 |
| opnd_imm | output | 64 | Extended immediate matching `opnd_sel` |
| reg_we | output | 1 | Register file write enable |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| wb_from_mem | output | 1 | Writeback takes memory data instead of the ALU result |

## Verification
The assertions assume that `insn` is a known value at every rising edge out of reset. They also assume that the value sampled at one edge is the one the next edge's outputs should reflect. The bench meets both assumptions by changing `insn` only on falling edges and by never leaving it undriven.

The field-relation properties compare against the word sampled at the previous edge. They are armed only from the second edge after reset is released, so the reset value of the output register is never compared with a stale word.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int INSN_W    = 32;
    localparam int OPC_W     = 11;
    localparam int REG_SEL_W = 5;
    localparam int DATA_W    = 64;
    localparam int UIMM_W    = 12;
    localparam int SOFF_W    = 9;

    typedef enum logic [2:0] {
        CLS_NONE     = 3'd0,
        CLS_ARITH_R  = 3'd1,
        CLS_ADD_IMM  = 3'd2,
        CLS_AND_IMM  = 3'd3,
        CLS_LOAD     = 3'd4,
        CLS_STORE    = 3'd5
    } insn_cls_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_AND = 2'b01,
        ALU_SUB = 2'b10,
        ALU_ORR = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG  = 2'd0,
        OPB_UIMM = 2'd1,
        OPB_SOFF = 2'd2
    } opb_sel_e;

    typedef struct packed {
        logic [REG_SEL_W-1:0] sel_a;
        logic [REG_SEL_W-1:0] sel_b;
        logic [REG_SEL_W-1:0] sel_w;
        alu_op_e              alu_op;
        opb_sel_e             opnd_sel;
        logic [DATA_W-1:0]    opnd_imm;
        logic                 reg_we;
        logic                 mem_rd;
        logic                 mem_wr;
        logic                 wb_from_mem;
    } ctl_t;

endpackage

// File: rtl/idec_classify.sv
module idec_classify
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output insn_cls_e        cls
);

    // opc holds instruction bits 31:21, opc[10] being bit 31
    always_comb begin
        cls = CLS_NONE;
        if ((opc ==? 11'b10001011??0) || (opc ==? 11'b11001011??0)) begin
            cls = CLS_ARITH_R;
        end else if (opc ==? 11'b10010001???) begin
            cls = CLS_ADD_IMM;
        end else if (opc ==? 11'b100100100??) begin
            cls = CLS_AND_IMM;
        end else if (opc ==? 11'b1?111000010) begin
            cls = CLS_LOAD;
        end else if (opc ==? 11'b1?111000000) begin
            cls = CLS_STORE;
        end
    end

endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
(
    input  insn_cls_e  cls,
    input  logic [1:0] arith_bits,
    output alu_op_e    alu_op,
    output opb_sel_e   opnd_sel,
    output logic       reg_we,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       wb_from_mem
);

    always_comb begin
        alu_op      = ALU_ADD;
        opnd_sel    = OPB_REG;
        reg_we      = 1'b0;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        wb_from_mem = 1'b0;
        unique case (cls)
            CLS_ARITH_R: begin
                alu_op = alu_op_e'(arith_bits);
                reg_we = 1'b1;
            end
            CLS_ADD_IMM: begin
                opnd_sel = OPB_UIMM;
                reg_we   = 1'b1;
            end
            CLS_AND_IMM: begin
                alu_op   = ALU_AND;
                opnd_sel = OPB_UIMM;
                reg_we   = 1'b1;
            end
            CLS_LOAD: begin
                opnd_sel    = OPB_SOFF;
                reg_we      = 1'b1;
                mem_rd      = 1'b1;
                wb_from_mem = 1'b1;
            end
            CLS_STORE: begin
                opnd_sel = OPB_SOFF;
                mem_wr   = 1'b1;
            end
            default: begin
                alu_op = ALU_ADD;
            end
        endcase
    end

endmodule

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [REG_SEL_W-1:0] fld_m,
    input  logic [REG_SEL_W-1:0] fld_n,
    input  logic [REG_SEL_W-1:0] fld_d,
    input  insn_cls_e            cls,
    output logic [REG_SEL_W-1:0] sel_a,
    output logic [REG_SEL_W-1:0] sel_b,
    output logic [REG_SEL_W-1:0] sel_w
);

    always_comb begin
        sel_a = fld_n;
        sel_w = fld_d;
        // a store reads its data register through the second port
        sel_b = (cls == CLS_STORE) ? fld_d : fld_m;
    end

endmodule

// File: rtl/idec_imm.sv
module idec_imm
    import idec_pkg::*;
(
    input  logic [UIMM_W-1:0] uimm,
    input  logic [SOFF_W-1:0] soff,
    input  opb_sel_e          opnd_sel,
    output logic [DATA_W-1:0] imm
);

    localparam int UPAD = DATA_W - UIMM_W;
    localparam int SPAD = DATA_W - SOFF_W;

    always_comb begin
        unique case (opnd_sel)
            OPB_UIMM: imm = {{UPAD{1'b0}}, uimm};
            OPB_SOFF: imm = {{SPAD{soff[SOFF_W-1]}}, soff};
            default:  imm = '0;
        endcase
    end

endmodule

// File: rtl/idec_unit.sv
module idec_unit
    import idec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [INSN_W-1:0]    insn,
    output logic [REG_SEL_W-1:0] sel_a,
    output logic [REG_SEL_W-1:0] sel_b,
    output logic [REG_SEL_W-1:0] sel_w,
    output logic [1:0]           alu_op,
    output logic [1:0]           opnd_sel,
    output logic [DATA_W-1:0]    opnd_imm,
    output logic                 reg_we,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 wb_from_mem
);

    insn_cls_e            cls;
    alu_op_e              c_alu;
    opb_sel_e             c_opb;
    logic                 c_we, c_rd, c_wr, c_wb;
    logic [REG_SEL_W-1:0] f_a, f_b, f_w;
    logic [DATA_W-1:0]    f_imm;
    ctl_t                 ctl_d, ctl_q;

    idec_classify u_cls (
        .opc (insn[31:21]),
        .cls (cls)
    );

    idec_ctrl u_ctrl (
        .cls         (cls),
        .arith_bits  (insn[30:29]),
        .alu_op      (c_alu),
        .opnd_sel    (c_opb),
        .reg_we      (c_we),
        .mem_rd      (c_rd),
        .mem_wr      (c_wr),
        .wb_from_mem (c_wb)
    );

    idec_fields u_fld (
        .fld_m (insn[20:16]),
        .fld_n (insn[9:5]),
        .fld_d (insn[4:0]),
        .cls   (cls),
        .sel_a (f_a),
        .sel_b (f_b),
        .sel_w (f_w)
    );

    idec_imm u_imm (
        .uimm     (insn[21:10]),
        .soff     (insn[20:12]),
        .opnd_sel (c_opb),
        .imm      (f_imm)
    );

    always_comb begin
        ctl_d             = '0;
        ctl_d.sel_a       = f_a;
        ctl_d.sel_b       = f_b;
        ctl_d.sel_w       = f_w;
        ctl_d.alu_op      = c_alu;
        ctl_d.opnd_sel    = c_opb;
        ctl_d.opnd_imm    = f_imm;
        ctl_d.reg_we      = c_we;
        ctl_d.mem_rd      = c_rd;
        ctl_d.mem_wr      = c_wr;
        ctl_d.wb_from_mem = c_wb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sel_a       = ctl_q.sel_a;
    assign sel_b       = ctl_q.sel_b;
    assign sel_w       = ctl_q.sel_w;
    assign alu_op      = ctl_q.alu_op;
    assign opnd_sel    = ctl_q.opnd_sel;
    assign opnd_imm    = ctl_q.opnd_imm;
    assign reg_we      = ctl_q.reg_we;
    assign mem_rd      = ctl_q.mem_rd;
    assign mem_wr      = ctl_q.mem_wr;
    assign wb_from_mem = ctl_q.wb_from_mem;

endmodule

// File: rtl/idec_unit_chk.sv
module idec_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [9:0]  insn_lo,
    input logic [4:0]  sel_a,
    input logic [4:0]  sel_w,
    input logic [1:0]  alu_op,
    input logic [1:0]  opnd_sel,
    input logic [63:0] opnd_imm,
    input logic        reg_we,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        wb_from_mem
);

    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!reg_we && !mem_rd && !mem_wr && opnd_sel == 2'd0));

    p_dest_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (sel_w == $past(insn_lo[4:0]) && sel_a == $past(insn_lo[9:5])));

    p_load_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_from_mem |-> (mem_rd && reg_we && opnd_sel == 2'd2));

    p_store_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (!reg_we && !wb_from_mem && opnd_sel == 2'd2));

    p_mem_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> alu_op == 2'b00);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && opnd_sel != 2'd3);

    p_reg_imm_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_sel == 2'd0 |-> opnd_imm == 64'd0);

endmodule

bind idec_unit idec_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_lo     (insn[9:0]),
    .sel_a       (sel_a),
    .sel_w       (sel_w),
    .alu_op      (alu_op),
    .opnd_sel    (opnd_sel),
    .opnd_imm    (opnd_imm),
    .reg_we      (reg_we),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .wb_from_mem (wb_from_mem)
);

// File: tb/idec_unit_tb.sv
`timescale 1ns/1ps
module idec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = 32'd0;
    logic [4:0]  sel_a, sel_b, sel_w;
    logic [1:0]  alu_op, opnd_sel;
    logic [63:0] opnd_imm;
    logic        reg_we, mem_rd, mem_wr, wb_from_mem;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    idec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .insn(insn),
        .sel_a(sel_a), .sel_b(sel_b), .sel_w(sel_w),
        .alu_op(alu_op), .opnd_sel(opnd_sel), .opnd_imm(opnd_imm),
        .reg_we(reg_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_from_mem(wb_from_mem)
    );

    // stimulus: bits 31:21, expected {we, rd, wr, wb, opnd_sel[1:0], alu_op[1:0]}
    localparam int NV = 16;
    localparam logic [10:0] V_OPC [NV] = '{
        11'b10001011000, 11'b10001011110, 11'b11001011010, 11'b10010001000,
        11'b10010001111, 11'b10010010000, 11'b10010010011, 11'b10111000010,
        11'b11111000010, 11'b10111000000, 11'b11111000000, 11'b10001011001,
        11'b10111000011, 11'b10010010100, 11'b00000000000, 11'b11101011000
    };
    localparam logic [7:0] V_EXP [NV] = '{
        8'b1000_0000, 8'b1000_0000, 8'b1000_0010, 8'b1000_0100,
        8'b1000_0100, 8'b1000_0101, 8'b1000_0101, 8'b1101_1000,
        8'b1101_1000, 8'b0010_1000, 8'b0010_1000, 8'b0000_0000,
        8'b0000_0000, 8'b0000_0000, 8'b0000_0000, 8'b0000_0000
    };

    function automatic string tag_of(input logic [7:0] e);
        if (e == 8'b1000_0000 || e == 8'b1000_0010) return "R4";
        if (e == 8'b1000_0100) return "R5";
        if (e == 8'b1000_0101) return "R6";
        if (e == 8'b1101_1000) return "R7";
        if (e == 8'b0010_1000) return "R8";
        return "R9";
    endfunction

    task automatic report_summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic expect_eq(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // full check of the registered outputs against the word w
    task automatic check_word(input logic [31:0] w, input logic [7:0] e);
        logic [63:0] imm_e;
        logic [4:0]  b_e;
        expect_eq(tag_of(e), {reg_we, mem_rd, mem_wr, wb_from_mem, opnd_sel, alu_op}, e);
        expect_eq("R3", {sel_a, sel_w}, {w[9:5], w[4:0]});
        b_e = e[5] ? w[4:0] : w[20:16];
        expect_eq("R3", sel_b, b_e);
        if (e[3:2] == 2'd1)      imm_e = {52'd0, w[21:10]};
        else if (e[3:2] == 2'd2) imm_e = {{55{w[20]}}, w[20:12]};
        else                     imm_e = 64'd0;
        expect_eq("R11", opnd_imm, imm_e);
        expect_eq("R10", mem_rd & mem_wr, 1'b0);
    endtask

    task automatic apply(input logic [31:0] w, input logic [7:0] e);
        @(negedge clk);
        insn = w;
        @(negedge clk);
        check_word(w, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset holds every output at zero even with a load presented
        insn = {11'b11111000010, 21'h1ABCDE};
        @(negedge clk);
        expect_eq("R1", {reg_we, mem_rd, mem_wr, wb_from_mem, opnd_sel, alu_op}, 8'd0);
        expect_eq("R1", {sel_a, sel_b, sel_w}, 15'd0);
        expect_eq("R1", opnd_imm, 64'd0);
        rst_n = 1'b1;

        // table walk with random low fields
        for (int pass = 0; pass < 4; pass++) begin
            for (int i = 0; i < NV; i++) begin
                apply({V_OPC[i], 21'($urandom)}, V_EXP[i]);
            end
        end

        // R9: random words outside the subset
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 2 == 0) w[31] = 1'b0;
            else            w[28:24] = 5'b00000;
            apply(w, 8'd0);
        end

        // R11: negative and positive offsets, maximal imm12
        apply({11'b11111000010, 1'b1, 8'h00, 12'h3E5}, 8'b1101_1000);
        apply({11'b10111000000, 1'b0, 8'hFF, 12'h001}, 8'b0010_1000);
        apply({10'b1001000100, 12'hFFF, 10'h3FF}, 8'b1000_0100);

        // R2: outputs hold between edges, then follow the new word
        apply({11'b10111000010, 21'h012345}, 8'b1101_1000);
        @(negedge clk);
        insn = {11'b10111000000, 21'h054321};
        #1;
        expect_eq("R2", {mem_rd, mem_wr}, 2'b10);
        @(negedge clk);
        expect_eq("R2", {mem_rd, mem_wr}, 2'b01);

        // R1: reset asserted mid-stream clears outputs after one edge
        insn = {11'b11111000010, 21'h1F0F0F};
        rst_n = 1'b0;
        @(negedge clk);
        expect_eq("R1", {reg_we, mem_rd, mem_wr, wb_from_mem, opnd_sel, alu_op}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_word(insn, 8'b1101_1000);

        done = 1'b1;
        report_summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report_summary();
            $finish;
        end
    end

endmodule